// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers a set of level-sensitive interrupt lines and drives two processor interrupt outputs. Each line has its own configuration register. The register holds a 4-bit priority, an enable, an output-select bit and an input-inversion bit. A write to that register changes only the fields whose guard bits are set in the same write word. So software can, for example, change a priority without touching the enable.

Each output has two registers: a priority threshold and a vector register. An output is raised while at least one line qualifies for it. The line that wins is the one with the highest priority, and the lowest index breaks a tie. Reading the vector register returns a programmable table base plus eight times the winning index. A read of the base alone (winner index 0) tells software that nothing is pending. Line 0 is reserved and never takes part.

All registers sit behind one plain synchronous read/write port. The block has no streaming data path, so the port carries no valid/ready handshake. A write takes effect at the clock edge where `wr_en_i` is high. Read data appears on `rdata_o` one cycle after `rd_en_i` and holds until the next read.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Line 0 is reserved. Its register reads as 0 and ignores writes, it never wins, and a winner index of 0 means no line qualifies for that output.
- R2: The line register for line i (1 to NUM_SRC-1) sits at address i. It holds the priority in bits 3:0, the enable in bit 16, the output select in bit 17 and the inversion bit in bit 18. A read returns these fields with every other bit, including the guard bits, as 0.
- R3: On a write to a line register, bit 25 guards the output select, bit 26 the enable, bit 27 the inversion bit and bit 28 the priority. A field changes only when its guard bit is 1 in that write.
- R4: A line with output select 0 can only raise output 0, and one with output select 1 can only raise output 1.
- R5: With the inversion bit at 0 a line is active when its input is 1. With the bit at 1 it is active when its input is 0.
- R6: A line qualifies for an output only when it is active, enabled, routed to that output, and its priority is strictly greater than that output's threshold. A line with priority 0 therefore never qualifies.
- R7: Among the lines that qualify, the highest priority wins, and among equal priorities the lowest index wins.
- R8: For output k, the threshold register is at address 0x80+2k (bits 3:0) and the vector register at 0x81+2k. Writing the vector register sets a 32-bit base. Reading it returns the base plus the winner index times 8. Both registers reset to 0.
- R9: `irq_o[k]` is high exactly when some line qualifies for output k. There is no latching: a change on the inputs or on a register shows on the outputs after one clock edge. Reset clears both outputs.
- R10: `rdata_o` is updated one cycle after `rd_en_i` with the value at `addr_i`, and keeps its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level interrupt inputs, one per line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 2 | Interrupt outputs 0 and 1 |

## Verification
The assertions assume that `src_i` and the register port are driven away from the active clock edge and are stable across it. They also assume that reads and writes never target the same address in one cycle. The bench drives every input on the falling edge and issues only one register access at a time. Inputs are changed only between complete checks, so each registered winner has settled before its vector is read.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int PRIO_W  = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_OUT = 2;

  localparam int B_EN   = 16;
  localparam int B_TGT  = 17;
  localparam int B_INV  = 18;
  localparam int G_TGT  = 25;
  localparam int G_EN   = 26;
  localparam int G_INV  = 27;
  localparam int G_PRIO = 28;

  localparam logic [ADDR_W-1:0] OUT_BASE_ADDR = 8'h80;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              en;
    logic              tgt;
    logic              inv;
  } line_cfg_t;
endpackage

// File: rtl/irq_line_regs.sv
module irq_line_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 71
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0]  src,
  output line_cfg_t           cfg [NUM_SRC],
  output logic [NUM_SRC-1:0]  act
);
  // line 0 is reserved: no storage, never active
  assign cfg[0] = '0;
  assign act[0] = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_line
    line_cfg_t cfg_q;
    logic      hit;
    assign hit = wr_en && (addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (hit) begin
        if (wdata[G_PRIO]) cfg_q.prio <= wdata[PRIO_W-1:0];
        if (wdata[G_EN])   cfg_q.en   <= wdata[B_EN];
        if (wdata[G_TGT])  cfg_q.tgt  <= wdata[B_TGT];
        if (wdata[G_INV])  cfg_q.inv  <= wdata[B_INV];
      end
    end

    assign cfg[i] = cfg_q;
    assign act[i] = src[i] ^ cfg_q.inv;
  end
endmodule

// File: rtl/irq_out_regs.sv
module irq_out_regs
  import irq_prio_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_OUT-1:0][PRIO_W-1:0]    thr,
  output logic [NUM_OUT-1:0][DATA_W-1:0]    base
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    localparam logic [ADDR_W-1:0] A_THR = OUT_BASE_ADDR + ADDR_W'(2*k);
    localparam logic [ADDR_W-1:0] A_VEC = OUT_BASE_ADDR + ADDR_W'(2*k + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr[k]  <= '0;
        base[k] <= '0;
      end else if (wr_en) begin
        if (addr == A_THR) thr[k]  <= wdata[PRIO_W-1:0];
        if (addr == A_VEC) base[k] <= wdata;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int   NUM_SRC = 71,
  parameter logic OUT_ID  = 1'b0,
  localparam int  IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] act,
  input  line_cfg_t          cfg [NUM_SRC],
  input  logic [PRIO_W-1:0]  thr,
  output logic               irq_q,
  output logic [IDX_W-1:0]   win_idx_q,
  output logic [PRIO_W-1:0]  win_prio_q
);
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;
  logic              found;

  // linear scan: strict greater-than keeps the lowest index on ties
  always_comb begin
    best_idx  = '0;
    best_prio = '0;
    found     = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (act[i] && cfg[i].en && (cfg[i].tgt == OUT_ID) &&
          (cfg[i].prio > thr) && (cfg[i].prio > best_prio)) begin
        best_prio = cfg[i].prio;
        best_idx  = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= 1'b0;
      win_idx_q  <= '0;
      win_prio_q <= '0;
    end else begin
      irq_q      <= found;
      win_idx_q  <= best_idx;
      win_prio_q <= best_prio;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int  NUM_SRC = 71,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [1:0]         irq_o
);
  line_cfg_t                          cfg [NUM_SRC];
  logic [NUM_SRC-1:0]                 act;
  logic [NUM_OUT-1:0][PRIO_W-1:0]     thr;
  logic [NUM_OUT-1:0][DATA_W-1:0]     base;
  logic [NUM_OUT-1:0][IDX_W-1:0]      win_idx;
  logic [NUM_OUT-1:0][PRIO_W-1:0]     win_prio;
  logic [DATA_W-1:0]                  rd_mux;

  irq_line_regs #(.NUM_SRC(NUM_SRC)) u_lines (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .src(src_i), .cfg(cfg), .act(act)
  );

  irq_out_regs u_outs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .thr(thr), .base(base)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_arb
    irq_arbiter #(.NUM_SRC(NUM_SRC), .OUT_ID(1'(k))) u_arb (
      .clk(clk), .rst_n(rst_n), .act(act), .cfg(cfg), .thr(thr[k]),
      .irq_q(irq_o[k]), .win_idx_q(win_idx[k]), .win_prio_q(win_prio[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i < ADDR_W'(NUM_SRC)) begin
      for (int i = 1; i < NUM_SRC; i++) begin
        if (addr_i == ADDR_W'(i)) begin
          rd_mux[PRIO_W-1:0] = cfg[i].prio;
          rd_mux[B_EN]       = cfg[i].en;
          rd_mux[B_TGT]      = cfg[i].tgt;
          rd_mux[B_INV]      = cfg[i].inv;
        end
      end
    end else begin
      for (int k = 0; k < NUM_OUT; k++) begin
        if (addr_i == OUT_BASE_ADDR + ADDR_W'(2*k))
          rd_mux = DATA_W'(thr[k]);
        if (addr_i == OUT_BASE_ADDR + ADDR_W'(2*k + 1))
          rd_mux = base[k] + DATA_W'({win_idx[k], 3'b000});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_prio_ctrl_checker.sv
module irq_prio_ctrl_checker #(
  parameter int IDX_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            irq,
  input logic [1:0][IDX_W-1:0] win_idx,
  input logic [1:0][3:0]       win_prio,
  input logic [1:0][3:0]       thr,
  input logic                  rd_en,
  input logic [7:0]            addr,
  input logic [31:0]           rdata
);
  for (genvar k = 0; k < 2; k++) begin : g_chk
    // R1: a raised output never carries the reserved index
    p_win_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] |-> win_idx[k] != '0);
    // R1: a quiet output reports index 0
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !irq[k] |-> win_idx[k] == '0);
    // R6: a raised output's winner beat the threshold it was judged against
    p_above_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[k] && $stable(thr[k])) |-> win_prio[k] > thr[k]);
    // R6: priority 0 never reaches an output
    p_prio_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] |-> win_prio[k] != 4'd0);
  end

  // R1: reads of the reserved line register return 0
  p_rsv_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'd0) |=> rdata == 32'd0);
  // R10: data stays put without a read
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_checker #(.IDX_W(IDX_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .win_idx(win_idx),
  .win_prio(win_prio), .thr(thr), .rd_en(rd_en_i), .addr(addr_i),
  .rdata(rdata_o)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int N = 71;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [1:0]   irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [3:0]  m_prio [N];
  logic        m_en [N], m_tgt [N], m_inv [N];
  logic [3:0]  m_thr [2];
  logic [31:0] m_base [2];

  always #4 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic int exp_win(int k);
    int best = 0;
    logic [3:0] bp = 0;
    for (int i = 1; i < N; i++) begin
      if ((src[i] ^ m_inv[i]) && m_en[i] && (int'(m_tgt[i]) == k) &&
          m_prio[i] > m_thr[k] && m_prio[i] > bp) begin
        bp = m_prio[i];
        best = i;
      end
    end
    return best;
  endfunction

  function automatic logic [31:0] line_word(int i);
    logic [31:0] w = '0;
    if (i == 0) return '0;
    w[3:0] = m_prio[i]; w[16] = m_en[i]; w[17] = m_tgt[i]; w[18] = m_inv[i];
    return w;
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (a >= 8'd1 && a < 8'(N)) begin
      if (d[28]) m_prio[a] = d[3:0];
      if (d[26]) m_en[a]   = d[16];
      if (d[25]) m_tgt[a]  = d[17];
      if (d[27]) m_inv[a]  = d[18];
    end
    for (int k = 0; k < 2; k++) begin
      if (a == 8'h80 + 8'(2*k)) m_thr[k]  = d[3:0];
      if (a == 8'h81 + 8'(2*k)) m_base[k] = d;
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] cfg_word(int p, bit en, bit tgt, bit inv);
    return 32'h1E00_0000 | {13'd0, inv, tgt, en, 12'd0, 4'(p)};
  endfunction

  task automatic check_all(string tag);
    logic [31:0] v;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      int w = exp_win(k);
      check({tag, " irq"}, {31'd0, irq[k]}, {31'd0, w != 0});
      rd(8'h81 + 8'(2*k), v);
      check({tag, " vector"}, v, m_base[k] + 32'(w * 8));
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_prio[i] = 0; m_en[i] = 0; m_tgt[i] = 0; m_inv[i] = 0;
    end
    for (int k = 0; k < 2; k++) begin m_thr[k] = 0; m_base[k] = 0; end
    repeat (3) @(negedge clk);
    // R9, R8: reset state
    check("R9 reset irq", {30'd0, irq}, 32'd0);
    check("R10 reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h80, v); check("R8 reset threshold", v, 32'd0);
    rd(8'h83, v); check("R8 reset vector", v, 32'd0);

    // R1: reserved line ignores writes
    wr(8'd0, cfg_word(9, 1, 0, 0));
    rd(8'd0, v); check("R1 line0 read", v, 32'd0);
    src[0] = 1'b1;
    check_all("R1 line0 idle");

    // R3: only guarded fields change
    wr(8'd5, 32'h1000_0000 | 32'h0007_0007);
    rd(8'd5, v); check("R3 prio only", v, 32'h0000_0007);
    wr(8'd5, 32'h0400_0000 | 32'h0001_000C);
    rd(8'd5, v); check("R3 enable only", v, 32'h0001_0007);
    // R2: guard bits read as zero
    wr(8'd5, 32'hFFFF_FFF3);
    rd(8'd5, v); check("R2 readback layout", v, 32'h0007_0003);
    wr(8'd5, cfg_word(0, 0, 0, 0));

    // R7: tie goes to the lower index, higher priority beats it
    wr(8'h81, 32'h0000_1000);
    wr(8'd3, cfg_word(5, 1, 0, 0));
    wr(8'd9, cfg_word(5, 1, 0, 0));
    src = '0; src[3] = 1; src[9] = 1;
    check_all("R7 tie");
    rd(8'h81, v); check("R7 tie index 3", v, 32'h0000_1018);
    wr(8'd9, cfg_word(6, 1, 0, 0));
    check_all("R7 higher prio");
    rd(8'h81, v); check("R8 vector idx 9", v, 32'h0000_1048);

    // R6: threshold boundary
    wr(8'h80, 32'd6);
    check_all("R6 thr equals prio");
    rd(8'h81, v); check("R6 winner falls back", v, 32'h0000_1000);
    wr(8'h80, 32'd4);
    check_all("R6 thr below");
    wr(8'd9, 32'h1000_0000);
    check_all("R6 prio zero");

    // R5: inversion
    wr(8'd3, cfg_word(5, 1, 0, 1));
    src[3] = 0;
    check_all("R5 inverted low active");
    src[3] = 1;
    check_all("R5 inverted high idle");

    // R4: routing to output 1
    wr(8'd9, cfg_word(7, 1, 1, 0));
    check_all("R4 route out1");
    // R9: level removal
    src[9] = 0;
    check_all("R9 level drop");

    // random phase
    for (int i = 1; i < N; i++)
      wr(8'(i), cfg_word($urandom % 16, ($urandom % 4) != 0, $urandom % 2, $urandom % 2));
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 4)
        0, 1: wr(8'(1 + $urandom % (N - 1)), $urandom);
        2:    wr(8'h80 + 8'(2 * ($urandom % 2)), $urandom % 6);
        default: wr(8'h81 + 8'(2 * ($urandom % 2)), $urandom & 32'hFFFF_FF00);
      endcase
      src = N'({$urandom, $urandom, $urandom});
      check_all("R7 random");
      if ($urandom % 4 == 0) begin
        int a = $urandom % N;
        rd(8'(a), v); check("R2 random readback", v, line_word(a));
      end
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule